// File: doc/BRIEF.md
# Receive-Monitor Status Descriptor Generator

This block turns per-MPDU receive events into fixed eight-word status descriptors for a receive-monitor path and streams them out one 32-bit word per beat. An upstream stage offers an MPDU through a valid/ready handshake. The offer carries a push reason, an error code, a fragment number, a frameless-BAR marker and four MPDU information words. The block adds per-PPDU context that it tracks itself: the status-buffer count, the PPDU identifier and the 64-bit status reference.

PPDU start, PPDU end and flush events come in as single-cycle pulses. When the delimiter option is on, each end or flush event creates an extra delimiter descriptor. This descriptor has the end-of-PPDU bit set and its MPDU-specific content cleared. At most one delimiter can be pending. Another end or flush that arrives while one is pending and not yet loaded is dropped.

The controller has three states. `ST_IDLE` waits for work. `ST_BODY` sends words 0 to 6. `ST_TAIL` sends word 7. The transitions are:
- *load* (`ST_IDLE` to `ST_BODY`): a pending delimiter is loaded, or an MPDU handshake completes.
- *advance* (`ST_BODY` to `ST_BODY`): a word is accepted and word 6 has not yet been sent.
- *to-tail* (`ST_BODY` to `ST_TAIL`): word 6 is accepted.
- *done* (`ST_TAIL` to `ST_IDLE`): word 7 is accepted.

Top module: `mon_desc_gen`

## Requirements
- R1: Each descriptor goes out as eight words, word 0 first, with `out_last` high only on word 7. `mpdu_ready` is low whenever a descriptor is in flight, so descriptors never interleave.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R3: An MPDU descriptor has the following content:
  - Words 0–3 are the MPDU information words, and words 4–5 are the low and high halves of the PPDU status reference.
  - Word 6 packs reason [1:0], error code [6:2], fragment number [10:7], frameless-BAR [11], status-buffer count [15:12] and end-of-PPDU [16]=0.
  - Word 6 bits [31:17] are zero.
- R4: Reason codes are 0 = error, 1 = routing and 2 = flush. An input reason of 3 is written as 0, and the error code is kept.
- R5: The fragment number is written only when the fragment flag (information word 2, bit 8) is set after masking. Otherwise word 6 bits [10:7] are zero.
- R6: A frameless-BAR descriptor has the following content:
  - Words 0 and 1 are zero.
  - Word 2 keeps only the sequence number [26:15] and the BAR flag [11].
  - Word 3 (peer metadata) is kept.
  - Word 6 bit 11 is set.
- R7: With the delimiter enabled, a PPDU-end or flush pulse yields a descriptor with the following content:
  - Word 6 bit 16 is 1.
  - Words 0–3 are zero.
  - The error, fragment and frameless-BAR fields are zero.
  - The reason is 1 for an end and 2 for a flush.
- R8: With the delimiter disabled, end and flush pulses produce no output.
- R9: The status-buffer count clears on PPDU start and rises by one per used-buffer pulse, saturating at 15. A PPDU start wins over a same-cycle pulse. A descriptor reports the count held before its load cycle.
- R10: Word 7 bits [15:0] carry the PPDU id captured at start when copying is enabled at that start, and 0 otherwise. Bits [31:16] are zero.
- R11: A delimiter that is pending goes out before any further MPDU. An MPDU accepted in the same cycle as an end pulse goes out before that delimiter.
- R12: After reset `out_valid` is low and `mpdu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_delim_en | input | 1 | Enables delimiter descriptors on end/flush |
| cfg_id_copy_en | input | 1 | Captures the PPDU id at start when high |
| ppdu_start | input | 1 | PPDU start pulse |
| ppdu_start_id | input | 16 | PPDU identifier offered with the start pulse |
| ppdu_start_ref | input | 64 | Status reference offered with the start pulse |
| ppdu_end | input | 1 | PPDU end pulse |
| ppdu_flush | input | 1 | Flush pulse |
| sbuf_used | input | 1 | One status buffer consumed |
| mpdu_valid | input | 1 | MPDU offer valid |
| mpdu_ready | output | 1 | MPDU offer accepted when high with valid |
| mpdu_reason | input | 2 | Push reason code |
| mpdu_err | input | 5 | Error code |
| mpdu_frag_num | input | 4 | Fragment number |
| mpdu_frameless | input | 1 | Frameless-BAR marker |
| mpdu_info | input | 128 | Information words 0–3, word 0 in bits [31:0] |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | 32 | Descriptor word |
| out_last | output | 1 | High on word 7 |

## Verification
Word 0 of an MPDU descriptor appears one cycle after the rising edge that completes the MPDU handshake. A delimiter needs one more edge, because the end or flush pulse first registers a pending request and the load follows on the next edge. After that, words advance one per cycle while `out_ready` is high. The bench changes inputs just after rising edges and samples on falling edges. It starts collecting at the first falling edge after the accepting edge, and at each sample it requires `out_valid` before reading a word. Checks of held data during a stall are also made on falling edges, one per stalled cycle.

// File: rtl/mon_desc_pkg.sv
package mon_desc_pkg;

    localparam int WORD_W     = 32;
    localparam int INFO_WORDS = 4;
    localparam int REF_W      = 64;
    localparam int REF_WORDS  = REF_W / WORD_W;
    localparam int DESC_WORDS = INFO_WORDS + REF_WORDS + 2;
    localparam int BEAT_W     = $clog2(DESC_WORDS);
    localparam int W6_IDX     = INFO_WORDS + REF_WORDS;
    localparam int W7_IDX     = W6_IDX + 1;

    localparam int ID_W   = 16;
    localparam int CNT_W  = 4;
    localparam int ERR_W  = 5;
    localparam int FRAG_W = 4;
    localparam int RSN_W  = 2;
    localparam int W6_USED = RSN_W + ERR_W + FRAG_W + 1 + CNT_W + 1;

    localparam logic [RSN_W-1:0] RSN_ERROR = 2'd0;
    localparam logic [RSN_W-1:0] RSN_ROUTE = 2'd1;
    localparam logic [RSN_W-1:0] RSN_FLUSH = 2'd2;
    localparam logic [RSN_W-1:0] RSN_BAD   = 2'd3;

    localparam int INFO_FLAG_WORD = 2;
    localparam int INFO_META_WORD = 3;
    localparam int INFO_FRAG_BIT  = 8;
    localparam int INFO_BAR_BIT   = 11;
    localparam int INFO_SEQ_LSB   = 15;
    localparam int INFO_SEQ_MSB   = 26;

    localparam int W6_FRAG_LSB = RSN_W + ERR_W;
    localparam int W6_BAR_BIT  = W6_FRAG_LSB + FRAG_W;
    localparam int W6_EOP_BIT  = W6_BAR_BIT + 1 + CNT_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_TAIL
    } gen_state_e;

    typedef struct packed {
        logic [REF_W-1:0] ref_addr;
        logic [ID_W-1:0]  id;
        logic [CNT_W-1:0] cnt;
    } ppdu_ctx_t;

    // Bits of an information word that survive in a frameless-BAR descriptor
    function automatic logic [WORD_W-1:0] fless_keep(input int idx);
        logic [WORD_W-1:0] m;
        m = '0;
        if (idx == INFO_META_WORD) begin
            m = '1;
        end else if (idx == INFO_FLAG_WORD) begin
            for (int b = INFO_SEQ_LSB; b <= INFO_SEQ_MSB; b++) m[b] = 1'b1;
            m[INFO_BAR_BIT] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mon_ppdu_track.sv
module mon_ppdu_track
    import mon_desc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ID_W-1:0]  start_id,
    input  logic [REF_W-1:0] start_ref,
    input  logic             copy_en,
    input  logic             buf_used,
    output ppdu_ctx_t        ctx
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx <= '0;
        end else if (start) begin
            ctx.cnt      <= '0;
            ctx.id       <= copy_en ? start_id : '0;
            ctx.ref_addr <= start_ref;
        end else if (buf_used && (ctx.cnt != CNT_MAX)) begin
            ctx.cnt <= ctx.cnt + 1'b1;
        end
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx.cnt == CNT_MAX && !start) |=> (ctx.cnt == CNT_MAX)); // R9
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ctx.cnt == '0)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !buf_used) |=> $stable(ctx.cnt)); // R9

endmodule

// File: rtl/mon_desc_pack.sv
module mon_desc_pack
    import mon_desc_pkg::*;
(
    input  logic                         is_delim,
    input  logic                         delim_flush,
    input  logic [RSN_W-1:0]             rsn_in,
    input  logic [ERR_W-1:0]             err_in,
    input  logic [FRAG_W-1:0]            frag_in,
    input  logic                         fless_in,
    input  logic [INFO_WORDS*WORD_W-1:0] info_in,
    input  ppdu_ctx_t                    ctx,
    output logic [DESC_WORDS*WORD_W-1:0] desc_flat
);

    logic [WORD_W-1:0] info_m [INFO_WORDS];
    logic [WORD_W-1:0] w6;
    logic [WORD_W-1:0] w7;
    logic [RSN_W-1:0]  rsn_eff;
    logic [ERR_W-1:0]  err_eff;
    logic [FRAG_W-1:0] frag_eff;
    logic              bar_eff;

    generate
        for (genvar g = 0; g < INFO_WORDS; g++) begin : g_info
            assign info_m[g] = is_delim ? '0 :
                               fless_in ? (info_in[g*WORD_W +: WORD_W] & fless_keep(g)) :
                                          info_in[g*WORD_W +: WORD_W];
            assign desc_flat[g*WORD_W +: WORD_W] = info_m[g];
        end
        for (genvar r = 0; r < REF_WORDS; r++) begin : g_ref
            assign desc_flat[(INFO_WORDS+r)*WORD_W +: WORD_W] = ctx.ref_addr[r*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        if (is_delim) begin
            rsn_eff = delim_flush ? RSN_FLUSH : RSN_ROUTE;
            err_eff = '0;
        end else begin
            rsn_eff = (rsn_in == RSN_BAD) ? RSN_ERROR : rsn_in;
            err_eff = err_in;
        end
        frag_eff = info_m[INFO_FLAG_WORD][INFO_FRAG_BIT] ? frag_in : '0;
        bar_eff  = !is_delim && fless_in;
        w6 = {{(WORD_W-W6_USED){1'b0}}, is_delim, ctx.cnt, bar_eff, frag_eff, err_eff, rsn_eff};
        w7 = {{(WORD_W-ID_W){1'b0}}, ctx.id};
    end

    assign desc_flat[W6_IDX*WORD_W +: WORD_W] = w6;
    assign desc_flat[W7_IDX*WORD_W +: WORD_W] = w7;

endmodule

// File: rtl/mon_desc_gen.sv
module mon_desc_gen
    import mon_desc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_delim_en,
    input  logic                         cfg_id_copy_en,
    input  logic                         ppdu_start,
    input  logic [ID_W-1:0]              ppdu_start_id,
    input  logic [REF_W-1:0]             ppdu_start_ref,
    input  logic                         ppdu_end,
    input  logic                         ppdu_flush,
    input  logic                         sbuf_used,
    input  logic                         mpdu_valid,
    output logic                         mpdu_ready,
    input  logic [RSN_W-1:0]             mpdu_reason,
    input  logic [ERR_W-1:0]             mpdu_err,
    input  logic [FRAG_W-1:0]            mpdu_frag_num,
    input  logic                         mpdu_frameless,
    input  logic [INFO_WORDS*WORD_W-1:0] mpdu_info,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [WORD_W-1:0]            out_data,
    output logic                         out_last
);

    localparam logic [BEAT_W-1:0] BEAT_W6 = BEAT_W'(W6_IDX);
    localparam logic [BEAT_W-1:0] BEAT_W7 = BEAT_W'(W7_IDX);

    gen_state_e                  state_q, state_d;
    logic [BEAT_W-1:0]           beat_q;
    logic [WORD_W-1:0]           desc_q [DESC_WORDS];
    logic                        pend_q, pend_flush_q;
    ppdu_ctx_t                   pend_ctx_q;
    ppdu_ctx_t                   ctx_now, ctx_sel;
    logic [DESC_WORDS*WORD_W-1:0] desc_flat;
    logic                        delim_evt, load_delim, load_mpdu, load_any, fire;

    mon_ppdu_track i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ppdu_start),
        .start_id  (ppdu_start_id),
        .start_ref (ppdu_start_ref),
        .copy_en   (cfg_id_copy_en),
        .buf_used  (sbuf_used),
        .ctx       (ctx_now)
    );

    assign ctx_sel = pend_q ? pend_ctx_q : ctx_now;

    mon_desc_pack i_pack (
        .is_delim    (pend_q),
        .delim_flush (pend_flush_q),
        .rsn_in      (mpdu_reason),
        .err_in      (mpdu_err),
        .frag_in     (mpdu_frag_num),
        .fless_in    (mpdu_frameless),
        .info_in     (mpdu_info),
        .ctx         (ctx_sel),
        .desc_flat   (desc_flat)
    );

    assign delim_evt  = cfg_delim_en && (ppdu_end || ppdu_flush);
    assign mpdu_ready = (state_q == ST_IDLE) && !pend_q;
    assign load_delim = (state_q == ST_IDLE) && pend_q;
    assign load_mpdu  = mpdu_valid && mpdu_ready;
    assign load_any   = load_delim || load_mpdu;
    assign fire       = out_valid && out_ready;

    // Pending delimiter slot: an event is taken when the slot is free or being emptied
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_flush_q <= 1'b0;
            pend_ctx_q   <= '0;
        end else if (delim_evt && (!pend_q || load_delim)) begin
            pend_q       <= 1'b1;
            pend_flush_q <= ppdu_flush;
            pend_ctx_q   <= ctx_now;
        end else if (load_delim) begin
            pend_q <= 1'b0;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_any) state_d = ST_BODY;
            ST_BODY: if (out_ready && beat_q == BEAT_W6) state_d = ST_TAIL;
            ST_TAIL: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, beat counter and descriptor store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            for (int k = 0; k < DESC_WORDS; k++) desc_q[k] <= '0;
        end else begin
            state_q <= state_d;
            if (load_any) begin
                beat_q <= '0;
                for (int k = 0; k < DESC_WORDS; k++) desc_q[k] <= desc_flat[k*WORD_W +: WORD_W];
            end else if (fire && state_q == ST_BODY) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BODY: begin
                out_valid = 1'b1;
                out_data  = desc_q[beat_q];
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
                out_data  = desc_q[beat_q];
            end
            default: ;
        endcase
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R2
    AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        mpdu_ready |-> !out_valid); // R1
    AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (beat_q == BEAT_W7)); // R1
    AST_W6_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q == BEAT_W6) |-> (out_data[WORD_W-1:W6_USED] == '0)); // R3
    AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q == BEAT_W6) |-> (out_data[RSN_W-1:0] != RSN_BAD)); // R4
    AST_FRAG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q == BEAT_W6 && !desc_q[INFO_FLAG_WORD][INFO_FRAG_BIT])
        |-> (out_data[W6_BAR_BIT-1:W6_FRAG_LSB] == '0)); // R5
    AST_DELIM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q == BEAT_W6 && out_data[W6_EOP_BIT])
        |-> (out_data[W6_BAR_BIT:RSN_W] == '0)); // R7
    AST_W7_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_data[WORD_W-1:ID_W] == '0)); // R10

endmodule

// File: tb/test_mon_desc_gen.sv
module test_mon_desc_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;
    localparam logic [63:0] REF_A = 64'hCAFE_0001_1234_5678;
    localparam logic [63:0] REF_B = 64'h0BAD_F00D_5A5A_A5A5;

    typedef struct packed {
        logic [1:0]  rsn;
        logic [4:0]  err;
        logic [3:0]  fnum;
        logic        fless;
        logic [31:0] w2;
        logic [31:0] exp_w2;
        logic [31:0] exp_w6;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd1, 5'd0,  4'd5, 1'b0, 32'h0000_0100, 32'h0000_0100, 32'h0000_0281},
        '{2'd0, 5'h1F, 4'd7, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_007C},
        '{2'd2, 5'd3,  4'hF, 1'b1, 32'hFFFF_FFFF, 32'h07FF_8800, 32'h0000_080E},
        '{2'd3, 5'd9,  4'hA, 1'b0, 32'hABCD_0100, 32'hABCD_0100, 32'h0000_0524}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_delim_en = 1'b0, cfg_id_copy_en = 1'b0;
    logic         ppdu_start = 1'b0, ppdu_end = 1'b0, ppdu_flush = 1'b0, sbuf_used = 1'b0;
    logic [15:0]  ppdu_start_id = '0;
    logic [63:0]  ppdu_start_ref = '0;
    logic         mpdu_valid = 1'b0;
    logic         mpdu_ready;
    logic [1:0]   mpdu_reason = '0;
    logic [4:0]   mpdu_err = '0;
    logic [3:0]   mpdu_frag_num = '0;
    logic         mpdu_frameless = 1'b0;
    logic [127:0] mpdu_info = '0;
    logic         out_valid, out_last;
    logic         out_ready = 1'b1;
    logic [31:0]  out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] got [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_desc_gen i_mon_desc_gen (
        .clk(clk), .rst_n(rst_n), .cfg_delim_en(cfg_delim_en), .cfg_id_copy_en(cfg_id_copy_en),
        .ppdu_start(ppdu_start), .ppdu_start_id(ppdu_start_id), .ppdu_start_ref(ppdu_start_ref),
        .ppdu_end(ppdu_end), .ppdu_flush(ppdu_flush), .sbuf_used(sbuf_used),
        .mpdu_valid(mpdu_valid), .mpdu_ready(mpdu_ready), .mpdu_reason(mpdu_reason),
        .mpdu_err(mpdu_err), .mpdu_frag_num(mpdu_frag_num), .mpdu_frameless(mpdu_frameless),
        .mpdu_info(mpdu_info), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic start_ppdu(input logic [15:0] id, input logic copy, input logic [63:0] rf);
        @(negedge clk);
        ppdu_start = 1'b1; ppdu_start_id = id; cfg_id_copy_en = copy; ppdu_start_ref = rf;
        @(posedge clk); #1;
        ppdu_start = 1'b0;
    endtask

    task automatic pulse_bufs(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sbuf_used = 1'b1;
            @(negedge clk); sbuf_used = 1'b0;
        end
    endtask

    task automatic pulse_end(input logic is_flush);
        @(negedge clk);
        if (is_flush) ppdu_flush = 1'b1; else ppdu_end = 1'b1;
        @(posedge clk); #1;
        ppdu_flush = 1'b0; ppdu_end = 1'b0;
    endtask

    task automatic send_mpdu(input logic [1:0] rsn, input logic [4:0] err, input logic [3:0] fn,
                             input logic fl, input logic [127:0] info);
        @(negedge clk);
        mpdu_reason = rsn; mpdu_err = err; mpdu_frag_num = fn; mpdu_frameless = fl; mpdu_info = info;
        mpdu_valid = 1'b1;
        while (!mpdu_ready) @(negedge clk);
        @(posedge clk); #1;
        mpdu_valid = 1'b0;
    endtask

    // Collects one descriptor; stalls for three cycles at beat stall_at (-1: none)
    task automatic collect(input int stall_at);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            while (!out_valid) @(negedge clk);
            got[b] = out_data;
            chk("R1 out_last position", {31'd0, out_last}, {31'd0, (b == 7)});
            if (b == stall_at) begin
                out_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    chk("R2 valid held in stall", {31'd0, out_valid}, 32'd1);
                    chk("R2 data held in stall", out_data, got[b]);
                end
                out_ready = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [127:0] info;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R12 mpdu_ready after reset", {31'd0, mpdu_ready}, 32'd1);
        @(negedge clk); rst_n = 1'b1;

        start_ppdu(16'h1234, 1'b1, REF_A);

        // Vector table: R3 R4 R5 R6 R10
        for (int i = 0; i < 4; i++) begin
            info = {32'h3000_0000 + i, VECS[i].w2, 32'h2000_0000 + i, 32'h1000_0000 + i};
            send_mpdu(VECS[i].rsn, VECS[i].err, VECS[i].fnum, VECS[i].fless, info);
            collect(-1);
            chk("R3/R6 word0", got[0], VECS[i].fless ? 32'h0 : 32'h1000_0000 + i);
            chk("R3/R6 word1", got[1], VECS[i].fless ? 32'h0 : 32'h2000_0000 + i);
            chk("R3/R6 word2", got[2], VECS[i].exp_w2);
            chk("R3/R6 word3", got[3], 32'h3000_0000 + i);
            chk("R3 word4 ref low", got[4], REF_A[31:0]);
            chk("R3 word5 ref high", got[5], REF_A[63:32]);
            chk("R3/R4/R5 word6", got[6], VECS[i].exp_w6);
            chk("R10 word7 id", got[7], 32'h0000_1234);
        end

        // R2: stall at word 2
        send_mpdu(2'd1, 5'd0, 4'd5, 1'b0, {32'h3, 32'h0000_0100, 32'h1, 32'h0});
        collect(2);
        chk("R2 word6 after stall", got[6], 32'h0000_0281);

        // R9: counting and saturation
        start_ppdu(16'h00AB, 1'b1, REF_A);
        pulse_bufs(3);
        send_mpdu(2'd1, 5'd0, 4'd0, 1'b0, '0);
        collect(-1);
        chk("R9 count of three", got[6], 32'h0000_3001);
        pulse_bufs(20);
        send_mpdu(2'd1, 5'd0, 4'd0, 1'b0, '0);
        collect(-1);
        chk("R9 count saturates", got[6], 32'h0000_F001);

        // R7: end delimiter
        cfg_delim_en = 1'b1;
        pulse_end(1'b0);
        collect(-1);
        for (int w = 0; w < 4; w++) chk("R7 delimiter info word zero", got[w], 32'h0);
        chk("R7 end delimiter word6", got[6], 32'h0001_F001);
        chk("R7 delimiter id", got[7], 32'h0000_00AB);

        // R7 flush delimiter, R10 copy disabled
        start_ppdu(16'h5555, 1'b0, REF_B);
        pulse_bufs(2);
        pulse_end(1'b1);
        collect(-1);
        chk("R7 flush delimiter word6", got[6], 32'h0001_2002);
        chk("R7 flush delimiter ref", got[4], REF_B[31:0]);
        chk("R10 id zero when copy off", got[7], 32'h0);

        // R9: clear on start
        start_ppdu(16'h0077, 1'b1, REF_A);
        send_mpdu(2'd1, 5'd0, 4'd0, 1'b0, '0);
        collect(-1);
        chk("R9 count cleared at start", got[6], 32'h0000_0001);
        chk("R10 new id", got[7], 32'h0000_0077);

        // R11: same-cycle MPDU and end
        @(negedge clk);
        mpdu_reason = 2'd1; mpdu_err = '0; mpdu_frag_num = '0; mpdu_frameless = 1'b0;
        mpdu_info = {32'hD3, 32'h0, 32'hD1, 32'hD0};
        mpdu_valid = 1'b1; ppdu_end = 1'b1;
        @(posedge clk); #1;
        mpdu_valid = 1'b0; ppdu_end = 1'b0;
        collect(-1);
        chk("R11 MPDU before same-cycle delimiter", got[6], 32'h0000_0001);
        chk("R11 MPDU word0", got[0], 32'hD0);
        collect(-1);
        chk("R11 delimiter follows", got[6], 32'h0001_0001);

        // R11: pending delimiter precedes a waiting MPDU
        send_mpdu(2'd1, 5'd0, 4'd0, 1'b0, {32'hA3, 32'h0, 32'hA1, 32'hA0});
        fork
            collect(-1);
            begin
                repeat (3) @(negedge clk);
                pulse_end(1'b0);
            end
        join
        chk("R11 first MPDU", got[0], 32'hA0);
        fork
            send_mpdu(2'd1, 5'd0, 4'd0, 1'b0, {32'hB3, 32'h0, 32'hB1, 32'hB0});
            begin
                collect(-1);
                chk("R11 pending delimiter first", got[6], 32'h0001_0001);
                collect(-1);
                chk("R11 waiting MPDU after delimiter", got[0], 32'hB0);
            end
        join

        // R8: delimiter disabled
        cfg_delim_en = 1'b0;
        pulse_end(1'b0);
        pulse_end(1'b1);
        begin
            logic seen;
            seen = 1'b0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            chk("R8 no output when disabled", {31'd0, seen}, 32'd0);
            chk("R8 ready stays high", {31'd0, mpdu_ready}, 32'd1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule